// File: doc/BRIEF.md
# Mode-Gated Interrupt Enable Controller

This block keeps the interrupt enable bits of a data-capture unit that runs either in trace mode or in direct-data mode, and it turns qualified events into a single interrupt line. Software changes the enables through two write strobes. The set strobe turns on every enable whose data bit is 1. The clear strobe turns off every enable whose data bit is 1. Both strobes take effect only when the access is marked privileged. The read data always shows the current enables, whatever the privilege level.

There are eighteen event inputs. Two are direct-data events: the buffer pointer matching its compare value, and a write to the last buffer entry that wraps the pointer. Eight are trace events, one for each region start address (four destinations with two regions each). Eight are error sources. An event is qualified when its enable is set and its mode group agrees with the `mode_direct` input. Error events qualify in either mode. The interrupt output is registered and pulses in the cycle after a qualified event.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset all enables read 0 and `irq` is 0.
- R2: A privileged write on `set_we` sets each enable whose `wdata` bit is 1. The change is visible on `rdata` one clock later. Bits written as 0 keep their value.
- R3: A privileged write on `clr_we` clears each enable whose `wdata` bit is 1. The change is visible one clock later. Bits written as 0 keep their value.
- R4: When `priv` is 0, writes on either strobe leave every enable unchanged.
- R5: Bits 31 to 18 of `rdata` always read 0, and writes to those bits have no effect.
- R6: When `set_we` and `clr_we` are both active in the same privileged cycle, every bit written as 1 ends up cleared.
- R7: Bit 17 enables the pointer-match event and bit 16 enables the buffer-wrap event. These two events count only when `mode_direct` is 1.
- R8: Bits 15 to 8 enable the region-start events. `ev_region[i]` maps to bit 8+i, with index 7 being destination 3 region 2 and index 0 being destination 0 region 1. These events count only when `mode_direct` is 0.
- R9: Bits 7 to 0 enable the error events, with `ev_err[i]` mapping to bit i (7 bus error, 6 buffer overflow, 5 source overflow, 4 to 1 destination 3 to 0 errors, 0 packet error). Error events count in both modes.
- R10: `irq` is 1 in the cycle after any qualified event and 0 after a cycle with no qualified event. An event whose enable is clear, or whose mode does not match, raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| set_we | input | 1 | Write strobe for the set view |
| clr_we | input | 1 | Write strobe for the clear view |
| priv | input | 1 | Access is privileged |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Current enables, zero-extended |
| mode_direct | input | 1 | 1 selects direct-data mode, 0 selects trace mode |
| ev_ptr_match | input | 1 | Buffer pointer equals its compare value |
| ev_buf_wrap | input | 1 | Last buffer entry written, pointer wrapped |
| ev_region | input | 8 | Region start-address write events |
| ev_err | input | 8 | Error events |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that the event inputs, strobes and `priv` change only between clock edges and hold steady for a whole cycle. They also assume that `mode_direct` is held for the cycle in which an event is sampled. The bench drives every input on the falling edge and samples on the next falling edge, so each value is seen by exactly one rising edge. Single-cycle event pulses are followed by an idle cycle whenever the bench needs to check that `irq` returns to 0.

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl #(
  parameter int DATA_W     = 32,
  parameter int NUM_REGION = 8,
  parameter int NUM_ERR    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_we,
  input  logic                  clr_we,
  input  logic                  priv,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic                  mode_direct,
  input  logic                  ev_ptr_match,
  input  logic                  ev_buf_wrap,
  input  logic [NUM_REGION-1:0] ev_region,
  input  logic [NUM_ERR-1:0]    ev_err,
  output logic                  irq
);
  localparam int EN_W  = NUM_ERR + NUM_REGION + 2;
  localparam int PAD_W = DATA_W - EN_W;

  logic [EN_W-1:0] en_q;
  logic [EN_W-1:0] set_mask, clr_mask, ev_vec, mode_ok;

  assign set_mask = (set_we && priv) ? wdata[EN_W-1:0] : '0;
  assign clr_mask = (clr_we && priv) ? wdata[EN_W-1:0] : '0;

  assign ev_vec  = {ev_ptr_match, ev_buf_wrap, ev_region, ev_err};
  assign mode_ok = {mode_direct, mode_direct, {NUM_REGION{~mode_direct}}, {NUM_ERR{1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      en_q <= (en_q | set_mask) & ~clr_mask;
      irq  <= |(ev_vec & en_q & mode_ok);
    end
  end

  assign rdata = {{PAD_W{1'b0}}, en_q};
endmodule

module irq_enable_ctrl_chk #(
  parameter int DATA_W     = 32,
  parameter int NUM_REGION = 8,
  parameter int NUM_ERR    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  set_we,
  input logic                  clr_we,
  input logic                  priv,
  input logic [DATA_W-1:0]     wdata,
  input logic [DATA_W-1:0]     rdata,
  input logic                  mode_direct,
  input logic                  ev_ptr_match,
  input logic                  ev_buf_wrap,
  input logic [NUM_REGION-1:0] ev_region,
  input logic [NUM_ERR-1:0]    ev_err,
  input logic                  irq
);
  localparam int EN_W = NUM_ERR + NUM_REGION + 2;
  localparam logic [DATA_W-1:0] LIVE = DATA_W'((64'd1 << EN_W) - 64'd1);

  // R2
  set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv && set_we && !clr_we) |=> ((rdata & ($past(wdata) & LIVE)) == ($past(wdata) & LIVE)));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv && clr_we) |=> ((rdata & $past(wdata)) == '0));

  // R4
  unpriv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv) |=> $stable(rdata));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~LIVE) == '0);

  // R10
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_ptr_match && !ev_buf_wrap && ev_region == '0 && ev_err == '0) |=> !irq);

  // R8
  trace_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_direct && !ev_ptr_match && !ev_buf_wrap && ev_err == '0) |=> !irq);
endmodule

bind irq_enable_ctrl irq_enable_ctrl_chk #(
  .DATA_W(DATA_W), .NUM_REGION(NUM_REGION), .NUM_ERR(NUM_ERR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we), .priv(priv),
  .wdata(wdata), .rdata(rdata), .mode_direct(mode_direct),
  .ev_ptr_match(ev_ptr_match), .ev_buf_wrap(ev_buf_wrap),
  .ev_region(ev_region), .ev_err(ev_err), .irq(irq)
);

// File: tb/sim_irq_enable_ctrl.sv
module sim_irq_enable_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_we = 1'b0, clr_we = 1'b0, priv = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic mode_direct = 1'b0;
  logic ev_ptr_match = 1'b0, ev_buf_wrap = 1'b0;
  logic [7:0] ev_region = '0, ev_err = '0;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_enable_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we), .priv(priv),
    .wdata(wdata), .rdata(rdata), .mode_direct(mode_direct),
    .ev_ptr_match(ev_ptr_match), .ev_buf_wrap(ev_buf_wrap),
    .ev_region(ev_region), .ev_err(ev_err), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit s, input bit c, input logic [31:0] d, input bit p);
    set_we = s; clr_we = c; wdata = d; priv = p;
    @(negedge clk);
    set_we = 0; clr_we = 0; wdata = '0; priv = 0;
  endtask

  task automatic pulse(input bit pm, input bit bw, input logic [7:0] rg, input logic [7:0] er, input bit exp, input string req);
    ev_ptr_match = pm; ev_buf_wrap = bw; ev_region = rg; ev_err = er;
    @(negedge clk);
    ev_ptr_match = 0; ev_buf_wrap = 0; ev_region = '0; ev_err = '0;
    check(irq == exp, req, {31'd0, irq}, {31'd0, exp});
    @(negedge clk);
    check(irq == 1'b0, "R10", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_reset();
    check(rdata == 32'd0, "R1", rdata, 32'd0);
    check(irq == 1'b0, "R1", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_set();
    wr(1, 0, 32'h0000_0081, 1);
    check(rdata == 32'h0000_0081, "R2", rdata, 32'h0000_0081);
    wr(1, 0, 32'h0002_0100, 1);
    check(rdata == 32'h0002_0181, "R2", rdata, 32'h0002_0181);
  endtask

  task automatic t_clear();
    wr(0, 1, 32'h0000_0001, 1);
    check(rdata == 32'h0002_0180, "R3", rdata, 32'h0002_0180);
    wr(0, 1, 32'h0003_FFFF, 1);
    check(rdata == 32'd0, "R3", rdata, 32'd0);
  endtask

  task automatic t_priv();
    wr(1, 0, 32'h0003_FFFF, 0);
    check(rdata == 32'd0, "R4", rdata, 32'd0);
    wr(1, 0, 32'h0000_00F0, 1);
    wr(0, 1, 32'h0000_00F0, 0);
    check(rdata == 32'h0000_00F0, "R4", rdata, 32'h0000_00F0);
    wr(0, 1, 32'h0000_00F0, 1);
  endtask

  task automatic t_reserved();
    wr(1, 0, 32'hFFFF_FFFF, 1);
    check(rdata == 32'h0003_FFFF, "R5", rdata, 32'h0003_FFFF);
  endtask

  task automatic t_collide();
    wr(1, 1, 32'h0000_FF00, 1);
    check(rdata == 32'h0003_00FF, "R6", rdata, 32'h0003_00FF);
    wr(0, 1, 32'h0003_FFFF, 1);
    wr(1, 1, 32'h0000_0005, 1);
    check(rdata == 32'd0, "R6", rdata, 32'd0);
  endtask

  task automatic t_direct();
    mode_direct = 1;
    pulse(1, 0, 8'h00, 8'h00, 0, "R7");
    wr(1, 0, 32'h0002_0000, 1);
    pulse(1, 0, 8'h00, 8'h00, 1, "R7");
    pulse(0, 1, 8'h00, 8'h00, 0, "R7");
    wr(1, 0, 32'h0001_0000, 1);
    pulse(0, 1, 8'h00, 8'h00, 1, "R7");
    mode_direct = 0;
    pulse(1, 1, 8'h00, 8'h00, 0, "R7");
    wr(0, 1, 32'h0003_0000, 1);
  endtask

  task automatic t_trace();
    mode_direct = 0;
    wr(1, 0, 32'h0000_8000, 1);
    pulse(0, 0, 8'h80, 8'h00, 1, "R8");
    pulse(0, 0, 8'h7F, 8'h00, 0, "R8");
    wr(0, 1, 32'h0000_8000, 1);
    wr(1, 0, 32'h0000_0100, 1);
    pulse(0, 0, 8'h01, 8'h00, 1, "R8");
    mode_direct = 1;
    pulse(0, 0, 8'h01, 8'h00, 0, "R8");
    wr(0, 1, 32'h0000_0100, 1);
  endtask

  task automatic t_err();
    wr(1, 0, 32'h0000_0041, 1);
    mode_direct = 1;
    pulse(0, 0, 8'h00, 8'h40, 1, "R9");
    mode_direct = 0;
    pulse(0, 0, 8'h00, 8'h01, 1, "R9");
    pulse(0, 0, 8'h00, 8'hBE, 0, "R9");
    wr(0, 1, 32'h0000_00FF, 1);
  endtask

  task automatic t_hold();
    wr(1, 0, 32'h0000_0002, 1);
    ev_err = 8'h02;
    @(negedge clk);
    check(irq == 1'b1, "R10", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check(irq == 1'b1, "R10", {31'd0, irq}, 32'd1);
    ev_err = '0;
    @(negedge clk);
    check(irq == 1'b0, "R10", {31'd0, irq}, 32'd0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set();
    t_clear();
    t_priv();
    t_reserved();
    t_collide();
    t_direct();
    t_trace();
    t_err();
    t_hold();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_up();
  end
endmodule